// File: doc/BRIEF.md
# Programmable Address Decode Window Unit

This block holds eight programmable address decode windows that sit between a CPU master and several targets. A 32-bit register port programs the windows. Each window has a control word and a base word. Each of the lowest-numbered windows also has a pair of translation words. For every request address presented with a valid strobe, the unit compares the address against all windows in parallel. One cycle later it reports a hit or a miss, together with the selected target ID, the attribute byte and the outgoing address.

A window covers a 64 KB-aligned region whose length is a whole number of 64 KB granules. A window that can translate replaces the upper address bits (those above the window's size) with a programmed translation base. Lower bits pass through unchanged. When windows overlap, the lowest-numbered one takes the request. Software clears a window by writing zero to its base and control words.

Top module: `adw_decoder`

## Requirements
- R1: Window n occupies register byte offsets 16*n to 16*n+15. Its control word is at +0x0, base at +0x4, translation-low at +0x8 and translation-high at +0xC. In the control word, bit 0 is enable, bits 7:4 are the target ID, bits 15:8 are the attribute and bits 31:16 are the size in 64 KB granules minus one. Bits 3:1 read back as zero.
- R2: Only bits 31:16 of the base word are stored. Bits 15:0 read as zero and have no effect on matching.
- R3: A window hits when it is enabled and (request & ~{size,16'hFFFF}) equals the stored base. An address one granule past the end of the window misses.
- R4: When several windows hit, the lowest-numbered window supplies the target, attribute and address.
- R5: On a hit in a window below REMAP_WIN (default 4), the outgoing address is the translation-low base in the bits above the size mask and the request bits under it. A hit in any other window passes the address through unchanged.
- R6: For windows at or above REMAP_WIN, the translation-low and translation-high words read as zero and writes to them are ignored.
- R7: On a translating window, translation-high stores all 32 bits and reads them back. It has no effect on the 32-bit outgoing address.
- R8: On a miss, the miss flag is high, the hit flag is low, the target and attribute are zero and the outgoing address equals the request address.
- R9: A result appears exactly one cycle after each cycle with request-valid high. Result-valid is low in the cycle after request-valid was low.
- R10: After reset every window is disabled and every register reads zero, so every request misses.
- R11: Writing zero to a window's base and control words disables that window. Requests it used to take then fall to the next matching window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (7) | Register byte address, shared by read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_valid | input | 1 | Request address valid |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Decode result valid |
| rsp_hit | output | 1 | Some window matched |
| rsp_miss | output | 1 | No window matched |
| rsp_target | output | 4 | Target ID of the winning window |
| rsp_attr | output | 8 | Attribute of the winning window |
| rsp_addr | output | 32 | Translated or passed-through address |

## Verification
The bench programs two windows that overlap. A design with the priority reversed would report the higher window's target and skip the translation. It sends addresses at the last byte of a window and at the first byte past it, so an off-by-one in the size mask shows up as a wrong hit or miss. The base is written with junk in its low half, the translation words of a non-translating window are written and read back, and translation-high is loaded with a non-zero pattern. These catch designs that store ignored bits or let the upper word leak into the address. It then clears a window and confirms that requests fall through to the next one, and it runs back-to-back requests to confirm the one-cycle result timing.

// File: rtl/adw_pkg.sv
package adw_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_BASE   = 2'd1,
        SEL_XLT_LO = 2'd2,
        SEL_XLT_HI = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [15:0] size;
        logic [7:0]  attr;
        logic [3:0]  tgt;
        logic        en;
    } win_cfg_t;

    localparam int GRANULE_BITS = 16;

endpackage

// File: rtl/adw_window.sv
module adw_window
    import adw_pkg::*;
#(
    parameter bit HAS_XLT = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  reg_sel_e    sel,
    input  logic [31:0] wdata,
    input  logic [31:0] req_addr,
    output logic [31:0] rdata,
    output logic        hit,
    output logic [3:0]  tgt,
    output logic [7:0]  attr,
    output logic [31:0] xlat_addr
);

    win_cfg_t    cfg;
    logic [15:0] base_hi;
    logic [31:0] keep_mask;
    logic [31:0] ctrl_word;
    logic [31:0] xlt_lo_word;
    logic [31:0] xlt_hi_word;
    logic        unused_wbits;

    assign unused_wbits = ^wdata[3:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg     <= '0;
            base_hi <= '0;
        end else if (wr_en) begin
            if (sel == SEL_CTRL) begin
                cfg.en   <= wdata[0];
                cfg.tgt  <= wdata[7:4];
                cfg.attr <= wdata[15:8];
                cfg.size <= wdata[31:16];
            end
            if (sel == SEL_BASE) begin
                base_hi <= wdata[31:16];
            end
        end
    end

    // Bits kept from the request: everything inside the window
    assign keep_mask = {cfg.size, {GRANULE_BITS{1'b1}}};
    assign hit       = cfg.en && ((req_addr & ~keep_mask) == {base_hi, 16'h0000});
    assign tgt       = cfg.tgt;
    assign attr      = cfg.attr;
    assign ctrl_word = {cfg.size, cfg.attr, cfg.tgt, 3'b000, cfg.en};

    generate
        if (HAS_XLT) begin : g_xlt
            logic [15:0] xlt_lo;
            logic [31:0] xlt_hi;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    xlt_lo <= '0;
                    xlt_hi <= '0;
                end else if (wr_en) begin
                    if (sel == SEL_XLT_LO) xlt_lo <= wdata[31:16];
                    if (sel == SEL_XLT_HI) xlt_hi <= wdata;
                end
            end

            assign xlt_lo_word = {xlt_lo, 16'h0000};
            assign xlt_hi_word = xlt_hi;
            assign xlat_addr   = (xlt_lo_word & ~keep_mask) | (req_addr & keep_mask);
        end else begin : g_plain
            assign xlt_lo_word = '0;
            assign xlt_hi_word = '0;
            assign xlat_addr   = req_addr;
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SEL_CTRL:   rdata = ctrl_word;
            SEL_BASE:   rdata = {base_hi, 16'h0000};
            SEL_XLT_LO: rdata = xlt_lo_word;
            SEL_XLT_HI: rdata = xlt_hi_word;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/adw_prio.sv
module adw_prio #(
    parameter int N = 8
) (
    input  logic [N-1:0]       hit,
    input  logic [N-1:0][3:0]  tgt,
    input  logic [N-1:0][7:0]  attr,
    input  logic [N-1:0][31:0] addr,
    input  logic [31:0]        pass_addr,
    output logic               any,
    output logic [3:0]         tgt_o,
    output logic [7:0]         attr_o,
    output logic [31:0]        addr_o
);

    // Walk from the top down so the lowest hitting index is applied last
    always_comb begin
        any    = |hit;
        tgt_o  = '0;
        attr_o = '0;
        addr_o = pass_addr;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                tgt_o  = tgt[i];
                attr_o = attr[i];
                addr_o = addr[i];
            end
        end
    end

endmodule

// File: rtl/adw_decoder.sv
module adw_decoder
    import adw_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int REMAP_WIN = 4,
    parameter int WIN_BITS  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    parameter int ADDR_W    = WIN_BITS + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [3:0]        rsp_target,
    output logic [7:0]        rsp_attr,
    output logic [31:0]       rsp_addr
);

    logic [WIN_BITS-1:0]      win_idx;
    reg_sel_e                 sel;
    logic [NUM_WIN-1:0]       win_wr;
    logic [NUM_WIN-1:0][31:0] win_rdata;
    logic [NUM_WIN-1:0]       win_hit;
    logic [NUM_WIN-1:0][3:0]  win_tgt;
    logic [NUM_WIN-1:0][7:0]  win_attr;
    logic [NUM_WIN-1:0][31:0] win_xlat;
    logic                     any_hit;
    logic [3:0]               sel_tgt;
    logic [7:0]               sel_attr;
    logic [31:0]              sel_addr;
    logic                     unused_lsb;

    assign unused_lsb = ^reg_addr[1:0];
    assign win_idx    = reg_addr[ADDR_W-1:4];
    assign sel        = reg_sel_e'(reg_addr[3:2]);

    generate
        for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
            assign win_wr[i] = reg_wr && (win_idx == WIN_BITS'(i));

            adw_window #(
                .HAS_XLT(i < REMAP_WIN)
            ) u_win (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (win_wr[i]),
                .sel      (sel),
                .wdata    (reg_wdata),
                .req_addr (req_addr),
                .rdata    (win_rdata[i]),
                .hit      (win_hit[i]),
                .tgt      (win_tgt[i]),
                .attr     (win_attr[i]),
                .xlat_addr(win_xlat[i])
            );
        end
    endgenerate

    always_comb begin
        if (int'(win_idx) < NUM_WIN) reg_rdata = win_rdata[win_idx];
        else                         reg_rdata = '0;
    end

    adw_prio #(
        .N(NUM_WIN)
    ) u_prio (
        .hit      (win_hit),
        .tgt      (win_tgt),
        .attr     (win_attr),
        .addr     (win_xlat),
        .pass_addr(req_addr),
        .any      (any_hit),
        .tgt_o    (sel_tgt),
        .attr_o   (sel_attr),
        .addr_o   (sel_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_miss   <= 1'b0;
            rsp_target <= '0;
            rsp_attr   <= '0;
            rsp_addr   <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && any_hit;
            rsp_miss  <= req_valid && !any_hit;
            if (req_valid) begin
                rsp_target <= sel_tgt;
                rsp_attr   <= sel_attr;
                rsp_addr   <= sel_addr;
            end
        end
    end

endmodule

// File: rtl/adw_decoder_checker.sv
module adw_decoder_checker #(
    parameter int NUM_WIN   = 8,
    parameter int REMAP_WIN = 4,
    parameter int ADDR_W    = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:2] reg_word,
    input logic [31:0]       reg_rdata,
    input logic              req_valid,
    input logic [31:0]       req_addr,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic [3:0]        rsp_target,
    input logic [7:0]        rsp_attr,
    input logic [31:0]       rsp_addr
);

    // R9: a result follows every request cycle, and only those
    a_r9_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R8: hit and miss are exclusive on a valid result, both low otherwise
    a_r8_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_miss));

    // R8: a miss reports zero target/attribute and the untouched address
    a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_target == 4'h0 && rsp_attr == 8'h00));
    a_r8_miss_pass: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_addr == $past(req_addr)));

    // R6: translation words of non-translating windows read zero
    a_r6_plain_xlt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(reg_word[ADDR_W-1:4]) >= REMAP_WIN) && (int'(reg_word[ADDR_W-1:4]) < NUM_WIN)
         && reg_word[3]) |-> (reg_rdata == 32'h0));

endmodule

bind adw_decoder adw_decoder_checker #(
    .NUM_WIN  (NUM_WIN),
    .REMAP_WIN(REMAP_WIN),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_word  (reg_addr[ADDR_W-1:2]),
    .reg_rdata (reg_rdata),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_target(rsp_target),
    .rsp_attr  (rsp_attr),
    .rsp_addr  (rsp_addr)
);

// File: tb/adw_decoder_test.sv
module adw_decoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic        hit;
        logic [3:0]  tgt;
        logic [7:0]  attr;
        logic [31:0] addr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [3:0]  rsp_target;
    logic [7:0]  rsp_attr;
    logic [31:0] rsp_addr;

    int   n_checks = 0;
    int   n_fails  = 0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    adw_decoder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_miss  (rsp_miss),
        .rsp_target(rsp_target),
        .rsp_attr  (rsp_attr),
        .rsp_addr  (rsp_addr)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_chk(input logic [6:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    // Driver: queue the expected result and present the request for one cycle
    task automatic send(input logic [31:0] a, input logic h, input logic [3:0] t,
                        input logic [7:0] at, input logic [31:0] xa, input string tag);
        exp_t e;
        e.hit = h; e.tgt = t; e.attr = at; e.addr = xa; e.tag = tag;
        sb.push_back(e);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compare each produced result with the oldest expected item
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check("R9 result without request", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " hit"},    {31'd0, rsp_hit},  {31'd0, e.hit});
                check({e.tag, " miss"},   {31'd0, rsp_miss}, {31'd0, !e.hit});
                check({e.tag, " target"}, {28'd0, rsp_target}, {28'd0, e.tgt});
                check({e.tag, " attr"},   {24'd0, rsp_attr}, {24'd0, e.attr});
                check({e.tag, " addr"},   rsp_addr, e.addr);
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        rd_chk(7'h00, 32'h0, "R10 win0 ctrl after reset");
        rd_chk(7'h74, 32'h0, "R10 win7 base after reset");
        send(32'h1234_5678, 1'b0, 4'h0, 8'h00, 32'h1234_5678, "R10/R8 miss after reset");
        idle();
        check("R9 valid low after idle", {31'd0, rsp_valid}, 32'd0);

        // Window 0: 1 MB at 0xF000_0000, translated to 0x0010_0000
        wr(7'h04, 32'hF000_ABCD);
        wr(7'h00, 32'h000F_514F);
        wr(7'h08, 32'h0010_1234);
        rd_chk(7'h04, 32'hF000_0000, "R2 base low bits dropped");
        rd_chk(7'h00, 32'h000F_5141, "R1 control readback");
        rd_chk(7'h08, 32'h0010_0000, "R5 translation-low readback");
        send(32'hF00A_BCDE, 1'b1, 4'h4, 8'h51, 32'h001A_BCDE, "R5 win0 translate");
        send(32'hF00F_FFFF, 1'b1, 4'h4, 8'h51, 32'h001F_FFFF, "R3 last byte of window");
        send(32'hF010_0000, 1'b0, 4'h0, 8'h00, 32'hF010_0000, "R3 one granule past end");
        send(32'hEFFF_FFFF, 1'b0, 4'h0, 8'h00, 32'hEFFF_FFFF, "R8 below window");
        idle();

        // Window 5: 64 KB at 0x8000_0000, no translation
        wr(7'h54, 32'h8000_0000);
        wr(7'h50, 32'h0000_1D11);
        wr(7'h58, 32'hFFFF_0000);
        wr(7'h5C, 32'hCAFE_F00D);
        rd_chk(7'h58, 32'h0, "R6 plain window translation-low reads zero");
        rd_chk(7'h5C, 32'h0, "R6 plain window translation-high reads zero");
        send(32'h8000_FFFF, 1'b1, 4'h1, 8'h1D, 32'h8000_FFFF, "R5/R6 plain window passes address");
        send(32'h8001_0000, 1'b0, 4'h0, 8'h00, 32'h8001_0000, "R3 plain window end");
        idle();

        // Window 2: 128 KB at 0x8000_0000 overlapping window 5, translated
        wr(7'h24, 32'h8000_0000);
        wr(7'h28, 32'h4000_0000);
        wr(7'h20, 32'h0001_5921);
        send(32'h8000_1234, 1'b1, 4'h2, 8'h59, 32'h4000_1234, "R4 lower window wins");
        send(32'h8001_0004, 1'b1, 4'h2, 8'h59, 32'h4001_0004, "R4 only win2 covers");
        idle();

        // R7: translation-high stored, no effect on address
        wr(7'h2C, 32'hDEAD_BEEF);
        rd_chk(7'h2C, 32'hDEAD_BEEF, "R7 translation-high readback");
        send(32'h8000_1234, 1'b1, 4'h2, 8'h59, 32'h4000_1234, "R7 high word ignored");
        idle();

        // R11: clearing window 2 lets window 5 take the request
        wr(7'h24, 32'h0);
        wr(7'h20, 32'h0);
        rd_chk(7'h20, 32'h0, "R11 cleared control");
        send(32'h8000_1234, 1'b1, 4'h1, 8'h1D, 32'h8000_1234, "R11 falls to win5");
        send(32'h8001_0004, 1'b0, 4'h0, 8'h00, 32'h8001_0004, "R11 cleared range misses");
        idle();
        idle();

        check("R9 every request answered", sb.size(), 32'd0);
        finish_run();
    end

endmodule